// File: doc/BRIEF.md
# Load-Linked / Store-Conditional Reservation Monitor

This unit sits in front of a single-port word memory that several requesters share. It gives them an atomic read-modify-write built from two operations. A load-linked reads a word and opens a reservation for the requester. A later store-conditional writes only if that reservation is still intact. The unit also passes plain loads and stores through to the memory.

Each requester owns a request slot, and the slot index is the requester ID. A slot carries a valid bit, a two-bit operation code, a word address and write data. The unit serves one request per cycle. When several slots are valid, the lowest index wins, and a requester holds its request until it sees its grant bit. The response appears one cycle after the grant. It gives the ID that was served, the read data and the outcome of a store-conditional (1 = the write happened). The requester branches on that bit and retries on 0.

The reservation table has one entry per requester. An entry holds a valid flag and a full word address. Committed stores from other requesters clear any entry that matches their address. A requester's own store-conditional consumes its entry.

Top module: `llsc_monitor`

## Requirements
- R1: After reset `rsp_valid` is 0 and no requester holds a reservation, so a store-conditional issued before any load-linked returns `rsp_sc_ok` = 0.
- R2: Grants are one-hot or zero. Among the valid slots, the lowest index is granted, and one request is served per cycle.
- R3: A request granted at a clock edge produces `rsp_valid` = 1 in the following cycle, with `rsp_id` equal to the granted index.
- R4: Operation codes are 0 = load, 1 = store, 2 = load-linked and 3 = store-conditional. Load and load-linked return the addressed word on `rsp_rdata`. A store writes the word. A load-linked also records a reservation for its requester on that address.
- R5: A store-conditional succeeds (`rsp_sc_ok` = 1) and writes memory when the requester's reservation is valid and matches the address.
- R6: A committed store from another requester to the reserved address clears the reservation. This covers both a plain store and a successful store-conditional. A later store-conditional on that address then fails and leaves memory unchanged.
- R7: Loads by other requesters, and stores to other addresses, do not clear a reservation.
- R8: A store-conditional to an address other than the reserved one fails and writes nothing.
- R9: Every store-conditional consumes the requester's reservation, so a second store-conditional without a new load-linked fails.
- R10: A new load-linked replaces the requester's earlier reservation. Stores to the old address no longer affect it.
- R11: A store and a store-conditional to the same address may be requested in the same cycle by different requesters. The store from the lower index is served first, and its invalidation applies to the store-conditional served in the next cycle, which then fails.
- R12: `rsp_sc_ok` is 0 for every operation except a successful store-conditional. `rsp_rdata` is 0 for store and store-conditional responses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | N_REQ | Request valid, one bit per requester |
| req_op | input | 2*N_REQ | Operation code per requester (slot i at bits 2i+1:2i) |
| req_addr | input | ADDR_W*N_REQ | Word address per requester |
| req_wdata | input | DATA_W*N_REQ | Write data per requester |
| req_grant | output | N_REQ | Combinational grant, one-hot or zero |
| rsp_valid | output | 1 | Response valid, one cycle after grant |
| rsp_id | output | ID_W | Index of the requester being answered |
| rsp_rdata | output | DATA_W | Read data for load and load-linked, else 0 |
| rsp_sc_ok | output | 1 | 1 when a store-conditional wrote memory |

## Verification
The case of interest is a plain store from one requester and a store-conditional from another that target the same reserved word and ask for service in the same cycle. The bench opens a reservation for the higher-index requester, then raises both requests on the same clock. It checks that the lower-index store holds the grant. It then checks that the store-conditional answered one cycle later reports failure, and that reading the word back returns the store's data rather than the conditional's.

// File: rtl/llsc_pkg.sv
package llsc_pkg;
    typedef enum logic [1:0] {
        OP_LD = 2'd0,
        OP_ST = 2'd1,
        OP_LL = 2'd2,
        OP_SC = 2'd3
    } llsc_op_e;
endpackage

// File: rtl/llsc_arb.sv
module llsc_arb #(
    parameter int N_REQ = 4,
    localparam int ID_W = (N_REQ > 1) ? $clog2(N_REQ) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_REQ-1:0] req,
    output logic [N_REQ-1:0] grant,
    output logic [ID_W-1:0]  grant_id,
    output logic             grant_any
);
    always_comb begin
        grant    = '0;
        grant_id = '0;
        for (int i = N_REQ - 1; i >= 0; i--) begin
            if (req[i]) begin
                grant    = '0;
                grant[i] = 1'b1;
                grant_id = ID_W'(i);
            end
        end
        grant_any = |req;
    end

    AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant)); // R2
    AST_GRANT_SERVES: assert property (@(posedge clk) disable iff (!rst_n)
        (|req) |-> ((grant & req) == grant) && (|grant)); // R2
    AST_GRANT_LOWEST: assert property (@(posedge clk) disable iff (!rst_n)
        (((grant - 1'b1) & req & ~grant) == '0)); // R2
endmodule

// File: rtl/llsc_resv.sv
module llsc_resv
    import llsc_pkg::*;
#(
    parameter int N_REQ  = 4,
    parameter int ADDR_W = 8,
    localparam int ID_W = (N_REQ > 1) ? $clog2(N_REQ) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_en,
    input  logic [ID_W-1:0]   op_id,
    input  llsc_op_e          op,
    input  logic [ADDR_W-1:0] op_addr,
    input  logic              wr_commit,
    output logic              hit
);
    typedef struct packed {
        logic [N_REQ-1:0]             vld;
        logic [N_REQ-1:0][ADDR_W-1:0] addr;
    } resv_t;

    resv_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        hit  = st_q.vld[op_id] && (st_q.addr[op_id] == op_addr);
        for (int i = 0; i < N_REQ; i++) begin
            if (op_en && (op_id == ID_W'(i))) begin
                if (op == OP_LL) begin
                    st_d.vld[i]  = 1'b1;
                    st_d.addr[i] = op_addr;
                end else if (op == OP_SC) begin
                    st_d.vld[i] = 1'b0;
                end
            end else if (op_en && wr_commit && (st_q.addr[i] == op_addr)) begin
                st_d.vld[i] = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    AST_LL_RESERVES: assert property (@(posedge clk) disable iff (!rst_n)
        (op_en && op == OP_LL) |=> st_q.vld[$past(op_id)]); // R4
    AST_SC_CONSUMES: assert property (@(posedge clk) disable iff (!rst_n)
        (op_en && op == OP_SC) |=> !st_q.vld[$past(op_id)]); // R9

    for (genvar g = 0; g < N_REQ; g++) begin : g_chk
        AST_STORE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
            (op_en && wr_commit && op_id != ID_W'(g) && st_q.vld[g] && st_q.addr[g] == op_addr)
            |=> !st_q.vld[g]); // R6
    end
endmodule

// File: rtl/llsc_mem.sv
module llsc_mem #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32,
    localparam int DEPTH = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic              re,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] mem_q [DEPTH];
    logic [DATA_W-1:0] rdata_d, rdata_q;

    always_comb begin
        rdata_d = re ? mem_q[addr] : '0;
    end

    always_ff @(posedge clk) begin
        if (we) begin
            mem_q[addr] <= wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else begin
            rdata_q <= rdata_d;
        end
    end

    assign rdata = rdata_q;

    AST_NO_RW_CLASH: assert property (@(posedge clk) disable iff (!rst_n)
        !(we && re)); // R4
endmodule

// File: rtl/llsc_monitor.sv
module llsc_monitor
    import llsc_pkg::*;
#(
    parameter int N_REQ  = 4,
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32,
    localparam int ID_W = (N_REQ > 1) ? $clog2(N_REQ) : 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [N_REQ-1:0]        req_valid,
    input  logic [2*N_REQ-1:0]      req_op,
    input  logic [ADDR_W*N_REQ-1:0] req_addr,
    input  logic [DATA_W*N_REQ-1:0] req_wdata,
    output logic [N_REQ-1:0]        req_grant,
    output logic                    rsp_valid,
    output logic [ID_W-1:0]         rsp_id,
    output logic [DATA_W-1:0]       rsp_rdata,
    output logic                    rsp_sc_ok
);
    typedef struct packed {
        logic            vld;
        logic [ID_W-1:0] id;
        logic            is_sc;
        logic            ok;
    } rsp_t;

    rsp_t st_d, st_q;

    logic [ID_W-1:0]   sel_id;
    logic              sel_any;
    llsc_op_e          sel_op;
    logic [ADDR_W-1:0] sel_addr;
    logic [DATA_W-1:0] sel_wdata;
    logic              resv_hit;
    logic              mem_we;
    logic              mem_re;

    llsc_arb #(.N_REQ(N_REQ)) i_arb (
        .clk       (clk),
        .rst_n     (rst_n),
        .req       (req_valid),
        .grant     (req_grant),
        .grant_id  (sel_id),
        .grant_any (sel_any)
    );

    always_comb begin
        sel_op    = llsc_op_e'(req_op[2*sel_id +: 2]);
        sel_addr  = req_addr[ADDR_W*sel_id +: ADDR_W];
        sel_wdata = req_wdata[DATA_W*sel_id +: DATA_W];
        mem_we    = sel_any && ((sel_op == OP_ST) || (sel_op == OP_SC && resv_hit));
        mem_re    = sel_any && ((sel_op == OP_LD) || (sel_op == OP_LL));
        st_d.vld   = sel_any;
        st_d.id    = sel_id;
        st_d.is_sc = sel_any && (sel_op == OP_SC);
        st_d.ok    = sel_any && (sel_op == OP_SC) && resv_hit;
    end

    llsc_resv #(.N_REQ(N_REQ), .ADDR_W(ADDR_W)) i_resv (
        .clk       (clk),
        .rst_n     (rst_n),
        .op_en     (sel_any),
        .op_id     (sel_id),
        .op        (sel_op),
        .op_addr   (sel_addr),
        .wr_commit (mem_we),
        .hit       (resv_hit)
    );

    llsc_mem #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_mem (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (mem_we),
        .re    (mem_re),
        .addr  (sel_addr),
        .wdata (sel_wdata),
        .rdata (rsp_rdata)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rsp_valid = st_q.vld;
    assign rsp_id    = st_q.id;
    assign rsp_sc_ok = st_q.ok;

    AST_RSP_AFTER_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        (|req_grant) |=> rsp_valid && (rsp_id == $past(sel_id))); // R3
    AST_SC_FAIL_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_any && sel_op == OP_SC && !resv_hit) |-> !mem_we); // R8
    AST_OK_ONLY_SC: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_sc_ok |-> st_q.is_sc && rsp_valid)); // R12
endmodule

// File: tb/test_llsc_monitor.sv
module test_llsc_monitor;
    localparam int N  = 4;
    localparam int AW = 8;
    localparam int DW = 32;
    localparam logic [1:0] LD = 2'd0, ST = 2'd1, LL = 2'd2, SC = 2'd3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  req_valid = '0;
    logic [2*N-1:0]  req_op = '0;
    logic [AW*N-1:0] req_addr = '0;
    logic [DW*N-1:0] req_wdata = '0;
    logic [N-1:0]  req_grant;
    logic          rsp_valid;
    logic [1:0]    rsp_id;
    logic [DW-1:0] rsp_rdata;
    logic          rsp_sc_ok;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    llsc_monitor #(.N_REQ(N), .ADDR_W(AW), .DATA_W(DW)) i_llsc_monitor (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_grant(req_grant),
        .rsp_valid(rsp_valid), .rsp_id(rsp_id), .rsp_rdata(rsp_rdata),
        .rsp_sc_ok(rsp_sc_ok)
    );

    typedef struct packed {
        logic [1:0]  id;
        logic [1:0]  op;
        logic [7:0]  addr;
        logic [31:0] wd;
        logic        ok;
        logic [31:0] rd;
        logic [3:0]  rq;
    } vec_t;

    localparam int NV = 26;
    localparam vec_t VEC [NV] = '{
        '{2'd0, ST, 8'h10, 32'h11, 1'b0, 32'h0,  4'd4},  // R4 R12 store
        '{2'd1, LD, 8'h10, 32'h0,  1'b0, 32'h11, 4'd4},  // R4 load
        '{2'd0, LL, 8'h10, 32'h0,  1'b0, 32'h11, 4'd4},  // R4 load-linked
        '{2'd1, LD, 8'h10, 32'h0,  1'b0, 32'h11, 4'd7},  // R7 other load
        '{2'd1, ST, 8'h11, 32'h22, 1'b0, 32'h0,  4'd7},  // R7 other address
        '{2'd0, SC, 8'h10, 32'h12, 1'b1, 32'h0,  4'd5},  // R5 success
        '{2'd0, LD, 8'h10, 32'h0,  1'b0, 32'h12, 4'd5},
        '{2'd0, SC, 8'h10, 32'h13, 1'b0, 32'h0,  4'd9},  // R9 consumed
        '{2'd0, LD, 8'h10, 32'h0,  1'b0, 32'h12, 4'd9},
        '{2'd2, LL, 8'h10, 32'h0,  1'b0, 32'h12, 4'd4},
        '{2'd3, ST, 8'h10, 32'h44, 1'b0, 32'h0,  4'd6},  // R6 plain store kills
        '{2'd2, SC, 8'h10, 32'h55, 1'b0, 32'h0,  4'd6},
        '{2'd2, LD, 8'h10, 32'h0,  1'b0, 32'h44, 4'd6},
        '{2'd1, LL, 8'h11, 32'h0,  1'b0, 32'h22, 4'd4},
        '{2'd1, SC, 8'h10, 32'h66, 1'b0, 32'h0,  4'd8},  // R8 wrong address
        '{2'd1, LD, 8'h10, 32'h0,  1'b0, 32'h44, 4'd8},
        '{2'd1, LL, 8'h11, 32'h0,  1'b0, 32'h22, 4'd10}, // R10 replace
        '{2'd1, LL, 8'h10, 32'h0,  1'b0, 32'h44, 4'd10},
        '{2'd3, ST, 8'h11, 32'h33, 1'b0, 32'h0,  4'd10},
        '{2'd1, SC, 8'h10, 32'h77, 1'b1, 32'h0,  4'd10},
        '{2'd1, LD, 8'h11, 32'h0,  1'b0, 32'h33, 4'd4},
        '{2'd0, LL, 8'h11, 32'h0,  1'b0, 32'h33, 4'd4},
        '{2'd2, LL, 8'h11, 32'h0,  1'b0, 32'h33, 4'd4},
        '{2'd0, SC, 8'h11, 32'h88, 1'b1, 32'h0,  4'd5},
        '{2'd2, SC, 8'h11, 32'h99, 1'b0, 32'h0,  4'd6},  // R6 SC kills
        '{2'd2, LD, 8'h11, 32'h0,  1'b0, 32'h88, 4'd6}
    };

    task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", rq, act, exp);
        end
    endtask

    task automatic drive(input int id, input logic [1:0] op, input logic [7:0] a, input logic [31:0] wd);
        req_valid[id]          = 1'b1;
        req_op[2*id +: 2]      = op;
        req_addr[AW*id +: AW]  = a;
        req_wdata[DW*id +: DW] = wd;
    endtask

    task automatic issue(input int id, input logic [1:0] op, input logic [7:0] a, input logic [31:0] wd);
        @(negedge clk);
        drive(id, op, a, wd);
        @(negedge clk);
        req_valid[id] = 1'b0;
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual hung expected finished");
            summary();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 idle rsp_valid", 32'(rsp_valid), 32'h0);
        issue(3, SC, 8'h10, 32'hDEAD);
        chk("R1 sc before any ll", 32'(rsp_sc_ok), 32'h0);
        chk("R3 rsp_id", 32'(rsp_id), 32'd3);

        for (int v = 0; v < NV; v++) begin
            issue(int'(VEC[v].id), VEC[v].op, VEC[v].addr, VEC[v].wd);
            chk($sformatf("R3 vec%0d valid", v), 32'(rsp_valid), 32'h1);
            chk($sformatf("R3 vec%0d id", v), 32'(rsp_id), 32'(VEC[v].id));
            chk($sformatf("R%0d vec%0d ok", VEC[v].rq, v), 32'(rsp_sc_ok), 32'(VEC[v].ok));
            chk($sformatf("R%0d vec%0d rdata", VEC[v].rq, v), rsp_rdata, VEC[v].rd);
        end

        // R11 / R2: store and store-conditional contend in one cycle
        issue(1, LL, 8'h10, 32'h0);
        chk("R4 ll rdata", rsp_rdata, 32'h77);
        @(negedge clk);
        drive(1, SC, 8'h10, 32'hBB);
        drive(0, ST, 8'h10, 32'hAA);
        #1;
        chk("R2 lowest index granted", 32'(req_grant), 32'h1);
        @(negedge clk);
        req_valid[0] = 1'b0;
        chk("R2 store answered first", 32'(rsp_id), 32'd0);
        #1;
        chk("R2 next grant", 32'(req_grant), 32'h2);
        @(negedge clk);
        req_valid[1] = 1'b0;
        chk("R11 sc id", 32'(rsp_id), 32'd1);
        chk("R11 sc fails", 32'(rsp_sc_ok), 32'h0);
        issue(2, LD, 8'h10, 32'h0);
        chk("R11 memory holds store", rsp_rdata, 32'hAA);
        @(negedge clk);
        chk("R3 idle after response", 32'(rsp_valid), 32'h0);

        done = 1'b1;
        summary();
    end
endmodule